// File: doc/BRIEF.md
# Set-Associative L1 Data Cache

This block is a data cache for a processor core. Each line holds 32 bytes and each set has 8 ways, and the number of sets is a parameter. The default of 128 sets gives 32 KB, and a bench can build a much smaller cache. The core sends one 32-bit word load or store per request. Each request carries a write-policy bit that selects copy-back or write-through handling for that access only. A load or store that hits finishes in one cycle.

A miss, or a write-through store, starts a single transaction on a simple request/acknowledge port to lower memory. That port moves whole lines for refills and evictions and single words for write-through stores. While that one transaction is in flight, the cache keeps accepting and answering hits. Any other request that needs memory is held off until the transaction finishes. Victims are chosen from invalid ways first and otherwise by a binary-tree pseudo-LRU. A dirty victim is written back before its refill is read.

Top module: `l1d_cache`

## Requirements
- R1: The word address is split into a line offset (bits 2:0, the word within the 8-word line), a set index (the next log2(SETS) bits) and a tag (the remaining upper bits). Loads return the 32-bit word at the request address.
- R2: After reset every line is invalid and the outputs are idle: coreReady=1, memReq=0 and rValid=0.
- R3: A load hit raises rValid in the cycle after acceptance, with the cached word, and starts no memory transaction.
- R4: A load miss issues one line read (memWrite=0, memLine=1, memAddr aligned to 32 bytes). After memAck, it answers with the word taken from the refill data. A line is never present in two ways of one set.
- R5: A copy-back store (coreWt=0) that hits updates the word and marks the line dirty, with no memory write. A copy-back store that misses refills the line, merges the stored word into it and marks it dirty.
- R6: A write-through store (coreWt=1) always issues one word write (memWrite=1, memLine=0, memAddr is the byte address, data in memWData[31:0]). On a hit it also updates the cached word. On a miss it does not allocate, so a later load to that line misses.
- R7: When the victim is valid and dirty, the whole line is written back (memWrite=1, memLine=1, the victim's own line address) before the refill read. The victim way is invalidated when the miss is accepted.
- R8: A miss fills the lowest-numbered invalid way of its set. When no way is invalid, a 7-bit tree per set picks the victim. Node 0 is the root, the children of node n are 2n+1 (bit 0) and 2n+2 (bit 1), and a bit value of 0 steers toward the lower-numbered half. Every hit or fill sets each node on the accessed way's path to point away from it.
- R9: While a memory transaction is pending, hits that need no memory are accepted and answered. A request that misses (including one to the line being refilled) or a write-through store sees coreReady=0 until the transaction completes. coreReady is also 0 in the cycle memAck completes a refill.
- R10: memReq, memAddr, memWrite and memLine stay unchanged until memAck. A one-cycle memAck completes the transaction, and refill data is taken in that cycle.
- R11: Every load response carries in rId the coreId given with that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 1 | Core request valid |
| coreWe | input | 1 | 1 = store, 0 = load |
| coreWt | input | 1 | Store policy: 1 = write-through, 0 = copy-back |
| coreWordAddr | input | 30 | Word address (byte address bits 31:2) |
| coreWData | input | 32 | Store data |
| coreId | input | ID_W (4) | Tag returned with the load response |
| coreReady | output | 1 | Request accepted when high with coreReq |
| rValid | output | 1 | Load response valid |
| rData | output | 32 | Load response data |
| rId | output | ID_W (4) | Tag of the answered load |
| memReq | output | 1 | Memory transaction request |
| memWrite | output | 1 | 1 = write, 0 = line read |
| memLine | output | 1 | 1 = whole line, 0 = single word |
| memAddr | output | 32 | Byte address of the line or word |
| memWData | output | LINE_BYTES*8 (256) | Write data (word writes use bits 31:0) |
| memRData | input | LINE_BYTES*8 (256) | Refill line data, valid with memAck |
| memAck | input | 1 | Transaction complete |

## Verification
Some properties are checked by assertions on every cycle. The memory request stays stable until it is acknowledged. No miss is accepted while a transaction is pending. A load hit is answered in the next cycle with its own tag. A copy-back store hit leaves the memory port quiet. No line is ever present in two ways. A refill lands only in a way already freed. Other behaviour only the bench's scenarios can show: data correctness across evictions, the order of the write-back before the refill, invalid-way-first filling, and the exact victim the pseudo-LRU tree picks after a given sequence of accesses.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL, ST_WTW} dcState_e;

  typedef struct packed {
    logic     hitRead;   // load hit: answer next cycle
    logic     hitWrite;  // store hit: update word
    logic     setDirty;  // store hit is copy-back
    logic     capture;   // latch request as the pending transaction
    logic     alloc;     // reserve victim way for a refill
    logic     install;   // refill data arrives this cycle
    dcState_e phase;     // current memory transaction
  } dcStrobe_t;
endpackage

// File: rtl/l1d_ctrl.sv
module l1d_ctrl
  import l1d_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      coreReq,
  input  logic      coreWe,
  input  logic      coreWt,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memAck,
  output logic      coreReady,
  output logic      memReq,
  output logic      memWrite,
  output logic      memLine,
  output dcStrobe_t st
);
  dcState_e state, stateNext;
  logic needMem, fillDone, acc;

  always_comb begin
    needMem   = !hit || (coreWe && coreWt);
    fillDone  = (state == ST_FILL) && memAck;
    coreReady = !fillDone && ((state == ST_IDLE) || !needMem);
    acc       = coreReq && coreReady;

    st.hitRead  = acc && hit && !coreWe;
    st.hitWrite = acc && hit && coreWe;
    st.setDirty = !coreWt;
    st.capture  = acc && needMem;
    st.alloc    = acc && !hit && !(coreWe && coreWt);
    st.install  = fillDone;
    st.phase    = state;

    memReq   = (state != ST_IDLE);
    memWrite = (state == ST_WBACK) || (state == ST_WTW);
    memLine  = (state != ST_WTW);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (st.alloc)        stateNext = victimDirty ? ST_WBACK : ST_FILL;
        else if (st.capture) stateNext = ST_WTW;
      end
      ST_WBACK: if (memAck) stateNext = ST_FILL;
      ST_FILL:  if (memAck) stateNext = ST_IDLE;
      ST_WTW:   if (memAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R6
  wt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && st.capture && hit && coreWe) |=> (memReq && memWrite && !memLine));
endmodule

// File: rtl/l1d_datapath.sv
module l1d_datapath
  import l1d_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int ID_W       = 4,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcStrobe_t         st,
  input  logic [29:0]       reqAddr,
  input  logic              reqWe,
  input  logic [31:0]       reqWData,
  input  logic [ID_W-1:0]   reqId,
  input  logic [LINE_W-1:0] memRData,
  output logic              hit,
  output logic              victimDirty,
  output logic [31:0]       memAddr,
  output logic [LINE_W-1:0] memWData,
  output logic              rValid,
  output logic [31:0]       rData,
  output logic [ID_W-1:0]   rId
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = 30 - OFF_W - IDX_W;
  localparam int TREE_W = WAYS - 1;
  localparam int SLOTS  = SETS * WAYS;
  localparam int SLOT_W = IDX_W + WAY_W;

  logic [TAG_W-1:0]  tagArr  [SLOTS];
  logic [LINE_W-1:0] dataArr [SLOTS];
  logic [SLOTS-1:0]  validBits, dirtyBits;
  logic [TREE_W-1:0] plruArr [SETS];

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [OFF_W-1:0] reqOff;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, victimWay;
  logic [SLOT_W-1:0] hitSlot, vicSlot, pendSlot;
  logic             freeFound;

  logic [29:0]       pendAddr;
  logic [31:0]       pendData;
  logic              pendWe;
  logic [ID_W-1:0]   pendId;
  logic [WAY_W-1:0]  pendWay;
  logic [TAG_W-1:0]  wbTag;
  logic [LINE_W-1:0] wbBuf, fillLine;
  logic [IDX_W-1:0]  pendIdx;
  logic [TAG_W-1:0]  pendTag;
  logic [OFF_W-1:0]  pendOff;

  function automatic logic [WAY_W-1:0] plruPick(input logic [TREE_W-1:0] t);
    logic [WAY_W-1:0] w;
    int node;
    w = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      w[WAY_W-1-l] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  function automatic logic [TREE_W-1:0] plruTouch(input logic [TREE_W-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] r;
    int node;
    r = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[29 -: TAG_W];
  assign pendOff = pendAddr[OFF_W-1:0];
  assign pendIdx = pendAddr[OFF_W +: IDX_W];
  assign pendTag = pendAddr[29 -: TAG_W];

  // Lookup and victim choice for the presented request
  always_comb begin
    hitWay    = '0;
    victimWay = plruPick(plruArr[reqIdx]);
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validBits[{reqIdx, WAY_W'(w)}] && (tagArr[{reqIdx, WAY_W'(w)}] == reqTag);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (!validBits[{reqIdx, WAY_W'(w)}]) begin
        victimWay = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
    hit         = |hitVec;
    hitSlot     = {reqIdx, hitWay};
    vicSlot     = {reqIdx, victimWay};
    victimDirty = !freeFound && dirtyBits[vicSlot];
    pendSlot    = {pendIdx, pendWay};
    fillLine    = memRData;
    if (pendWe) fillLine[{pendOff, 5'b0} +: 32] = pendData;
  end

  // Memory side: address and data for the current transaction
  always_comb begin
    memWData = {{(LINE_W-32){1'b0}}, pendData};
    case (st.phase)
      ST_WBACK: begin
        memAddr  = {wbTag, pendIdx, {(OFF_W+2){1'b0}}};
        memWData = wbBuf;
      end
      ST_FILL: memAddr = {pendAddr[29:OFF_W], {(OFF_W+2){1'b0}}};
      default: memAddr = {pendAddr, 2'b00};
    endcase
  end

  // Tag and data storage (no reset)
  always_ff @(posedge clk) begin
    if (st.hitWrite) dataArr[hitSlot][{reqOff, 5'b0} +: 32] <= reqWData;
    if (st.alloc) wbBuf <= dataArr[vicSlot];
    if (st.alloc) wbTag <= tagArr[vicSlot];
    if (st.install) begin
      dataArr[pendSlot] <= fillLine;
      tagArr[pendSlot]  <= pendTag;
    end
  end

  // State bits, pending transaction and response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
      for (int s = 0; s < SETS; s++) plruArr[s] <= '0;
      pendAddr <= '0;
      pendData <= '0;
      pendWe   <= 1'b0;
      pendId   <= '0;
      pendWay  <= '0;
      rValid   <= 1'b0;
      rData    <= '0;
      rId      <= '0;
    end else begin
      if (st.hitRead || st.hitWrite) plruArr[reqIdx] <= plruTouch(plruArr[reqIdx], hitWay);
      else if (st.install)           plruArr[pendIdx] <= plruTouch(plruArr[pendIdx], pendWay);
      if (st.hitWrite && st.setDirty) dirtyBits[hitSlot] <= 1'b1;
      if (st.capture) begin
        pendAddr <= reqAddr;
        pendData <= reqWData;
        pendWe   <= reqWe;
        pendId   <= reqId;
      end
      if (st.alloc) begin
        pendWay            <= victimWay;
        validBits[vicSlot] <= 1'b0;
        dirtyBits[vicSlot] <= 1'b0;
      end
      if (st.install) begin
        validBits[pendSlot] <= 1'b1;
        dirtyBits[pendSlot] <= pendWe;
      end
      rValid <= st.hitRead || (st.install && !pendWe);
      if (st.hitRead) begin
        rData <= dataArr[hitSlot][{reqOff, 5'b0} +: 32];
        rId   <= reqId;
      end else if (st.install) begin
        rData <= memRData[{pendOff, 5'b0} +: 32];
        rId   <= pendId;
      end
    end
  end

  // R4
  one_copy_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec));

  // R7
  fill_slot_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.install |-> !validBits[pendSlot]);
endmodule

// File: rtl/l1d_cache.sv
module l1d_cache
  import l1d_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int ID_W       = 4,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic              coreWt,
  input  logic [29:0]       coreWordAddr,
  input  logic [31:0]       coreWData,
  input  logic [ID_W-1:0]   coreId,
  output logic              coreReady,
  output logic              rValid,
  output logic [31:0]       rData,
  output logic [ID_W-1:0]   rId,
  output logic              memReq,
  output logic              memWrite,
  output logic              memLine,
  output logic [31:0]       memAddr,
  output logic [LINE_W-1:0] memWData,
  input  logic [LINE_W-1:0] memRData,
  input  logic              memAck
);
  dcStrobe_t st;
  logic hitFlag, victimDirty;

  l1d_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreWe(coreWe), .coreWt(coreWt),
    .hit(hitFlag), .victimDirty(victimDirty), .memAck(memAck),
    .coreReady(coreReady), .memReq(memReq), .memWrite(memWrite), .memLine(memLine),
    .st(st)
  );

  l1d_datapath #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(coreWordAddr), .reqWe(coreWe),
    .reqWData(coreWData), .reqId(coreId), .memRData(memRData),
    .hit(hitFlag), .victimDirty(victimDirty), .memAddr(memAddr), .memWData(memWData),
    .rValid(rValid), .rData(rData), .rId(rId)
  );

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memLine)));

  // R9
  one_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && coreReq && coreReady) |-> (hitFlag && !(coreWe && coreWt)));

  // R3
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && coreReady && !coreWe && hitFlag) |=> (rValid && rId == $past(coreId)));

  // R5
  cb_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && coreReq && coreReady && coreWe && !coreWt && hitFlag) |=> !memReq);
endmodule

// File: tb/l1d_cache_tb.sv
`timescale 1ns/1ps
module l1d_cache_tb;
  localparam int SETS = 4;
  localparam int LW   = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreReq = 1'b0, coreWe = 1'b0, coreWt = 1'b0;
  logic [29:0] coreWordAddr = '0;
  logic [31:0] coreWData = '0;
  logic [3:0]  coreId = '0;
  logic coreReady, rValid, memReq, memWrite, memLine;
  logic [31:0] rData, memAddr;
  logic [3:0]  rId;
  logic [LW-1:0] memWData;
  logic [LW-1:0] memRData = '0;
  logic memAck = 1'b0;

  always #2.5 clk = ~clk;

  l1d_cache #(.SETS(SETS)) u_dut (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreWe(coreWe), .coreWt(coreWt),
    .coreWordAddr(coreWordAddr), .coreWData(coreWData), .coreId(coreId),
    .coreReady(coreReady), .rValid(rValid), .rData(rData), .rId(rId),
    .memReq(memReq), .memWrite(memWrite), .memLine(memLine), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .memAck(memAck)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] bmem [512];
  logic [31:0] golden [512];
  logic [31:0] expD [16];
  bit          pendV [16];
  int          respCyc [16];
  int ackDelay = 2, waitCnt = 2;
  bit randLat = 0;
  int seq = 0, rdCnt = 0, lineWrCnt = 0, wordWrCnt = 0;
  int lastRdSeq = 0, lastWrSeq = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastWrWord0 = '0, lastWordAddr = '0, lastWordData = '0;
  int accCyc = 0;
  logic [3:0] nextId = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Lower memory model
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        memAck = 1'b1;
        seq++;
        if (!memWrite) begin
          rdCnt++; lastRdAddr = memAddr; lastRdSeq = seq;
          for (int k = 0; k < 8; k++) memRData[k*32 +: 32] = bmem[{memAddr[10:5], 3'(k)}];
        end else if (memLine) begin
          lineWrCnt++; lastWrAddr = memAddr; lastWrSeq = seq; lastWrWord0 = memWData[31:0];
          for (int k = 0; k < 8; k++) bmem[{memAddr[10:5], 3'(k)}] = memWData[k*32 +: 32];
        end else begin
          wordWrCnt++; lastWordAddr = memAddr; lastWordData = memWData[31:0];
          bmem[memAddr[10:2]] = memWData[31:0];
        end
        waitCnt = randLat ? int'($urandom % 5) : ackDelay;
      end
    end
  end

  // Response monitor (R11, data per R3/R4)
  always @(negedge clk) begin
    if (rstN && rValid) begin
      if (!pendV[rId]) chk(1'b0, "R11 unexpected rId", 32'(rId), 32'hFFFF_FFFF);
      else begin
        chk(rData == expD[rId], "R4 load data", rData, expD[rId]);
        respCyc[rId] = cyc;
        pendV[rId] = 1'b0;
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; coreReq = 1'b0; memAck = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 512; i++) golden[i] = bmem[i];
    for (int i = 0; i < 16; i++) pendV[i] = 1'b0;
    waitCnt = ackDelay;
    rstN = 1'b1;
  endtask

  // Issue one request; returns after acceptance. Gives the used id.
  task automatic issue(input bit we, input bit wt, input logic [31:0] a,
                       input logic [31:0] d, output logic [3:0] id);
    @(negedge clk);
    id = nextId; nextId = nextId + 1;
    coreReq = 1'b1; coreWe = we; coreWt = wt; coreWordAddr = a[31:2];
    coreWData = d; coreId = id;
    #1;
    while (!coreReady) begin
      @(negedge clk);
      #1;
    end
    accCyc = cyc;
    if (we) golden[a[10:2]] = d;
    else begin expD[id] = golden[a[10:2]]; pendV[id] = 1'b1; end
    @(posedge clk);
    #0.5 coreReq = 1'b0;
  endtask

  task automatic probeStall(input bit we, input bit wt, input logic [31:0] a, input string req);
    @(negedge clk);
    coreReq = 1'b1; coreWe = we; coreWt = wt; coreWordAddr = a[31:2]; coreWData = 32'hDEAD_0000;
    coreId = 4'hF;
    #1;
    chk(!coreReady, req, 32'(coreReady), 32'd0);
    coreReq = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (memReq || memAck) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitResp(input logic [3:0] id);
    int n;
    n = 0;
    while (pendV[id] && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  function automatic logic [2:0] treePick(input logic [6:0] t);
    int node = 0;
    logic [2:0] w = '0;
    for (int l = 0; l < 3; l++) begin
      w[2-l] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  function automatic logic [6:0] treeTouch(input logic [6:0] t, input logic [2:0] w);
    int node = 0;
    for (int l = 0; l < 3; l++) begin
      t[node] = ~w[2-l];
      node = 2 * node + 1 + int'(w[2-l]);
    end
    return t;
  endfunction

  initial begin
    logic [3:0] id, idMiss;
    int r0, w0, ww0, lw0;
    int wayLine [8];
    logic [6:0] tree;
    logic [2:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) bmem[i] = (i * 32'h0101_0101) ^ 32'h5A5A_0000;

    doReset();
    @(negedge clk);
    // R2 reset state
    chk(coreReady == 1'b1, "R2 coreReady", 32'(coreReady), 32'd1);
    chk(memReq == 1'b0, "R2 memReq", 32'(memReq), 32'd0);
    chk(rValid == 1'b0, "R2 rValid", 32'(rValid), 32'd0);

    // R4 load miss, R1 word select
    r0 = rdCnt;
    issue(0, 0, 32'h48, 0, id);
    waitResp(id);
    chk(rdCnt == r0 + 1, "R4 one line read", 32'(rdCnt - r0), 32'd1);
    chk(lastRdAddr == 32'h40, "R4 line-aligned read address", lastRdAddr, 32'h40);

    // R3 load hit next cycle, no memory traffic
    issue(0, 0, 32'h44, 0, id);
    waitResp(id);
    chk(respCyc[id] == accCyc + 1, "R3 hit latency", 32'(respCyc[id] - accCyc), 32'd1);
    chk(rdCnt == r0 + 1, "R3 no read on hit", 32'(rdCnt), 32'(r0 + 1));

    // R5 copy-back store hit
    w0 = lineWrCnt; ww0 = wordWrCnt;
    issue(1, 0, 32'h48, 32'hC0FF_EE01, id);
    repeat (4) @(negedge clk);
    chk(wordWrCnt == ww0 && lineWrCnt == w0, "R5 no memory write", 32'(wordWrCnt - ww0), 32'd0);
    issue(0, 0, 32'h48, 0, id);
    waitResp(id);
    chk(respCyc[id] == accCyc + 1, "R5 store data hit", 32'(respCyc[id] - accCyc), 32'd1);

    // R6 write-through store hit
    issue(1, 1, 32'h4C, 32'h1234_5678, id);
    waitIdle();
    chk(wordWrCnt == ww0 + 1, "R6 one word write", 32'(wordWrCnt - ww0), 32'd1);
    chk(lastWordAddr == 32'h4C, "R6 word address", lastWordAddr, 32'h4C);
    chk(lastWordData == 32'h1234_5678, "R6 word data", lastWordData, 32'h1234_5678);
    issue(0, 0, 32'h4C, 0, id);
    waitResp(id);

    // R6 write-through store miss: no allocate
    issue(1, 1, 32'h104, 32'hABCD_0104, id);
    waitIdle();
    chk(lastWordAddr == 32'h104, "R6 miss word address", lastWordAddr, 32'h104);
    r0 = rdCnt;
    issue(0, 0, 32'h104, 0, id);
    waitResp(id);
    chk(rdCnt == r0 + 1, "R6 no allocate on miss", 32'(rdCnt - r0), 32'd1);

    // R9 hits under one outstanding miss
    ackDelay = 10; waitCnt = 10;
    issue(0, 0, 32'h200, 0, idMiss);
    @(negedge clk);
    chk(memReq == 1'b1, "R9 miss pending", 32'(memReq), 32'd1);
    issue(0, 0, 32'h44, 0, id);
    waitResp(id);
    chk(respCyc[id] == accCyc + 1, "R9 hit under miss", 32'(respCyc[id] - accCyc), 32'd1);
    chk(pendV[idMiss] == 1'b1, "R9 miss still pending", 32'(pendV[idMiss]), 32'd1);
    probeStall(0, 0, 32'h300, "R9 second miss stalls");
    probeStall(0, 0, 32'h204, "R9 same-line load stalls");
    probeStall(1, 1, 32'h44, "R9 write-through stalls");
    waitResp(idMiss);
    waitIdle();
    issue(0, 0, 32'h204, 0, id);
    waitResp(id);
    chk(respCyc[id] == accCyc + 1, "R9 refilled line hits", 32'(respCyc[id] - accCyc), 32'd1);
    ackDelay = 2; waitCnt = 2;

    // R7 / R8 replacement in set 0
    doReset();
    lw0 = lineWrCnt; r0 = rdCnt;
    tree = '0;
    for (int k = 0; k < 8; k++) begin
      issue(1, 0, 32'(k * 4 * 32), 32'hA000_0000 + 32'(k), id);
      waitIdle();
      wayLine[k] = k * 4;
      tree = treeTouch(tree, 3'(k));
    end
    chk(lineWrCnt == lw0, "R8 invalid ways filled first", 32'(lineWrCnt - lw0), 32'd0);
    chk(rdCnt == r0 + 8, "R5 store miss refills", 32'(rdCnt - r0), 32'd8);
    issue(0, 0, 32'(wayLine[3] * 32), 0, id);
    waitResp(id);
    tree = treeTouch(tree, 3'd3);
    v = treePick(tree);
    issue(1, 0, 32'(32 * 32), 32'hBEEF_0020, id);
    waitIdle();
    chk(lastWrAddr == 32'(wayLine[v] * 32), "R8 pseudo-LRU victim", lastWrAddr, 32'(wayLine[v] * 32));
    chk(lastWrWord0 == 32'hA000_0000 + 32'(v), "R7 write-back data", lastWrWord0, 32'hA000_0000 + 32'(v));
    chk(lastWrSeq < lastRdSeq, "R7 write-back before refill", 32'(lastWrSeq), 32'(lastRdSeq));
    chk(lastRdAddr == 32'(32 * 32), "R7 refill address", lastRdAddr, 32'(32 * 32));
    wayLine[v] = 32;
    tree = treeTouch(tree, v);
    v = treePick(tree);
    issue(1, 0, 32'(36 * 32), 32'hBEEF_0024, id);
    waitIdle();
    chk(lastWrAddr == 32'(wayLine[v] * 32), "R8 second victim", lastWrAddr, 32'(wayLine[v] * 32));

    // Random mix against the golden model (R1, R3-R6, R9, R11)
    doReset();
    randLat = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, d;
      bit we, wt;
      a  = 32'(($urandom % 64) * 32 + ($urandom % 8) * 4);
      d  = $urandom;
      we = ($urandom % 2) == 0;
      wt = ($urandom % 3) == 0;
      issue(we, wt, a, d, id);
      if (($urandom % 4) == 0) @(negedge clk);
    end
    for (int i = 0; i < 16; i++) waitResp(4'(i));
    waitIdle();
    // R1 readback after traffic
    for (int i = 0; i < 16; i++) begin
      issue(0, 0, 32'(i * 4 * 32 + 8), 0, id);
      waitResp(id);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule